// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block is the hazard steering logic for a five-stage in-order pipeline with fetch, decode, execute, memory and write-back stages. Every cycle it looks at the opcodes held in the decode, execute and memory pipeline registers, the two source register identifiers being read in decode, the register that a load in execute will write, and the branch condition computed in execute. From these it decides, per stage, whether the pipeline register should hold its value (stall) or be loaded with a no-operation (bubble) at the next rising clock edge.

Three situations are handled: a register read in decode that depends on a load or pop still in execute, a conditional jump in execute that turns out not to be taken although the fetch path assumed it would be, and a return instruction travelling down the pipeline whose target is not yet known. The logic is purely combinational; the pipeline registers it drives apply its outputs on the following edge. Operand forwarding and exception status are handled elsewhere.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: With no load or pop in execute, no return (opcode 9) in decode, execute or memory, and no not-taken conditional jump in execute, all four outputs are low.
- R2: A load/use hazard is flagged when the execute opcode is a load (opcode 5) or a pop (opcode 11) and the execute load destination equals the decode source A or source B identifier.
- R3: On a load/use hazard alone, f_stall, d_stall and e_bubble are high and d_bubble is low.
- R4: A not-taken conditional jump (execute opcode 7 with e_cond low) alone drives d_bubble and e_bubble high with f_stall and d_stall low.
- R5: A conditional jump in execute with e_cond high causes no stall or bubble by itself.
- R6: A return opcode (9) in any of the decode, execute or memory stages alone drives f_stall and d_bubble high with d_stall and e_bubble low.
- R7: When a load/use hazard and a return in flight coincide, the load/use action wins: f_stall, d_stall and e_bubble high, d_bubble low.
- R8: When a not-taken jump and a return in flight coincide, f_stall, d_bubble and e_bubble are high and d_stall is low.
- R9: Register identifier 15 means no register and never produces a load/use match, even when both compared identifiers are 15.
- R10: d_stall and d_bubble are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| d_src_a | input | 4 | First source register identifier read in decode |
| d_src_b | input | 4 | Second source register identifier read in decode |
| d_op | input | 4 | Opcode in the decode pipeline register |
| e_op | input | 4 | Opcode in the execute pipeline register |
| m_op | input | 4 | Opcode in the memory pipeline register |
| e_dst_m | input | 4 | Register that the execute-stage instruction writes from memory |
| e_cond | input | 1 | Branch condition computed in execute (1 = taken) |
| f_stall | output | 1 | Hold the fetch PC register at the next edge |
| d_stall | output | 1 | Hold the decode pipeline register at the next edge |
| d_bubble | output | 1 | Load a no-operation into decode at the next edge |
| e_bubble | output | 1 | Load a no-operation into execute at the next edge |

## Verification
The bench sweeps every combination of a small opcode set in the three stages, both branch outcomes and register identifiers drawn from two real registers and the no-register code. The sharp corners are the coincidences: a unit that let a return override a load/use stall would bubble decode and lose the instruction waiting there, and one that dropped the fetch stall under a misprediction plus return would fetch down the wrong path. Matching the no-register code as a real register would insert spurious stalls, and treating pop as something other than a load would read stale data. A taken jump must leave the pipeline untouched, otherwise every correctly predicted branch would pay two cycles.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
   localparam int unsigned REG_W_DEF = 4;
   localparam int unsigned OP_W_DEF  = 4;
   localparam logic [3:0] OP_LOAD_DEF = 4'd5;
   localparam logic [3:0] OP_POP_DEF  = 4'd11;
   localparam logic [3:0] OP_JCC_DEF  = 4'd7;
   localparam logic [3:0] OP_RET_DEF  = 4'd9;

   typedef struct packed {
      logic f_stall;
      logic d_stall;
      logic d_bubble;
      logic e_bubble;
   } stage_ctl_t;
endpackage

// File: rtl/hzd_loaduse.sv
module hzd_loaduse #(
   parameter int unsigned REG_W = 4,
   parameter int unsigned OP_W  = 4,
   parameter int unsigned NSRC  = 2,
   parameter logic [OP_W-1:0] OP_LOAD = 5,
   parameter logic [OP_W-1:0] OP_POP  = 11
) (
   input  logic [NSRC*REG_W-1:0] src_ids,
   input  logic [OP_W-1:0]       ex_op,
   input  logic [REG_W-1:0]      ex_dst,
   output logic                  hit
);
   localparam logic [REG_W-1:0] NO_REG = {REG_W{1'b1}};

   logic [NSRC-1:0] match;
   logic            ex_is_load;
   logic            dst_valid;

   assign dst_valid  = (ex_dst != NO_REG);
   assign ex_is_load = (ex_op == OP_LOAD) || (ex_op == OP_POP);

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign match[i] = dst_valid && (src_ids[i*REG_W +: REG_W] == ex_dst);
   end

   assign hit = ex_is_load && (|match);
endmodule

// File: rtl/hzd_mispredict.sv
module hzd_mispredict #(
   parameter int unsigned OP_W = 4,
   parameter logic [OP_W-1:0] OP_JCC = 7
) (
   input  logic [OP_W-1:0] ex_op,
   input  logic            ex_cond,
   output logic            hit
);
   assign hit = (ex_op == OP_JCC) && !ex_cond;
endmodule

// File: rtl/hzd_ret_track.sv
module hzd_ret_track #(
   parameter int unsigned OP_W  = 4,
   parameter int unsigned NSTG  = 3,
   parameter logic [OP_W-1:0] OP_RET = 9
) (
   input  logic [NSTG*OP_W-1:0] stage_ops,
   output logic                 hit
);
   logic [NSTG-1:0] is_ret;

   for (genvar s = 0; s < NSTG; s++) begin : g_stg
      assign is_ret[s] = (stage_ops[s*OP_W +: OP_W] == OP_RET);
   end

   assign hit = |is_ret;
endmodule

// File: rtl/hzd_merge.sv
module hzd_merge (
   input  logic                  load_use,
   input  logic                  mispredict,
   input  logic                  ret_active,
   output hzd_pkg::stage_ctl_t   ctl
);
   always_comb begin
      ctl = '0;
      if (load_use) begin
         ctl.f_stall  = 1'b1;
         ctl.d_stall  = 1'b1;
         ctl.e_bubble = 1'b1;
      end else begin
         if (ret_active) begin
            ctl.f_stall  = 1'b1;
            ctl.d_bubble = 1'b1;
         end
         if (mispredict) begin
            ctl.d_bubble = 1'b1;
            ctl.e_bubble = 1'b1;
         end
      end
   end
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl #(
   parameter int unsigned REG_W = hzd_pkg::REG_W_DEF,
   parameter int unsigned OP_W  = hzd_pkg::OP_W_DEF,
   parameter logic [OP_W-1:0] OP_LOAD = hzd_pkg::OP_LOAD_DEF,
   parameter logic [OP_W-1:0] OP_POP  = hzd_pkg::OP_POP_DEF,
   parameter logic [OP_W-1:0] OP_JCC  = hzd_pkg::OP_JCC_DEF,
   parameter logic [OP_W-1:0] OP_RET  = hzd_pkg::OP_RET_DEF
) (
   input  logic [REG_W-1:0] d_src_a,
   input  logic [REG_W-1:0] d_src_b,
   input  logic [OP_W-1:0]  d_op,
   input  logic [OP_W-1:0]  e_op,
   input  logic [OP_W-1:0]  m_op,
   input  logic [REG_W-1:0] e_dst_m,
   input  logic             e_cond,
   output logic             f_stall,
   output logic             d_stall,
   output logic             d_bubble,
   output logic             e_bubble
);
   localparam int unsigned NSRC = 2;
   localparam int unsigned NSTG = 3;

   if (REG_W < 2) begin : g_bad_reg
      $error("pipe_hazard_ctl: REG_W must be at least 2");
   end
   if (OP_W < 2) begin : g_bad_op
      $error("pipe_hazard_ctl: OP_W must be at least 2");
   end
   if (OP_RET == OP_JCC || OP_RET == OP_LOAD || OP_RET == OP_POP || OP_JCC == OP_LOAD || OP_JCC == OP_POP) begin : g_bad_codes
      $error("pipe_hazard_ctl: hazard opcodes must be distinct");
   end

   logic lu_hit;
   logic mp_hit;
   logic rt_hit;
   hzd_pkg::stage_ctl_t ctl;

   hzd_loaduse #(
      .REG_W(REG_W), .OP_W(OP_W), .NSRC(NSRC),
      .OP_LOAD(OP_LOAD), .OP_POP(OP_POP)
   ) u_loaduse (
      .src_ids ({d_src_b, d_src_a}),
      .ex_op   (e_op),
      .ex_dst  (e_dst_m),
      .hit     (lu_hit)
   );

   hzd_mispredict #(.OP_W(OP_W), .OP_JCC(OP_JCC)) u_mispredict (
      .ex_op   (e_op),
      .ex_cond (e_cond),
      .hit     (mp_hit)
   );

   hzd_ret_track #(.OP_W(OP_W), .NSTG(NSTG), .OP_RET(OP_RET)) u_ret (
      .stage_ops ({m_op, e_op, d_op}),
      .hit       (rt_hit)
   );

   hzd_merge u_merge (
      .load_use   (lu_hit),
      .mispredict (mp_hit),
      .ret_active (rt_hit),
      .ctl        (ctl)
   );

   assign f_stall  = ctl.f_stall;
   assign d_stall  = ctl.d_stall;
   assign d_bubble = ctl.d_bubble;
   assign e_bubble = ctl.e_bubble;
endmodule

// File: rtl/pipe_hazard_ctl_chk.sv
module pipe_hazard_ctl_chk #(
   parameter int unsigned REG_W = 4,
   parameter int unsigned OP_W  = 4,
   parameter logic [OP_W-1:0] OP_LOAD = 5,
   parameter logic [OP_W-1:0] OP_POP  = 11,
   parameter logic [OP_W-1:0] OP_JCC  = 7,
   parameter logic [OP_W-1:0] OP_RET  = 9
) (
   input logic [REG_W-1:0] d_src_a,
   input logic [REG_W-1:0] d_src_b,
   input logic [OP_W-1:0]  d_op,
   input logic [OP_W-1:0]  e_op,
   input logic [OP_W-1:0]  m_op,
   input logic [REG_W-1:0] e_dst_m,
   input logic             e_cond,
   input logic             f_stall,
   input logic             d_stall,
   input logic             d_bubble,
   input logic             e_bubble
);
   localparam logic [REG_W-1:0] NO_REG = {REG_W{1'b1}};

   logic known;
   logic ret_any;
   logic ld_op;

   always_comb begin
      known   = !$isunknown({d_src_a, d_src_b, d_op, e_op, m_op, e_dst_m, e_cond,
                             f_stall, d_stall, d_bubble, e_bubble});
      ret_any = (d_op == OP_RET) || (e_op == OP_RET) || (m_op == OP_RET);
      ld_op   = (e_op == OP_LOAD) || (e_op == OP_POP);
      if (known) begin
         a_r10_no_stall_and_bubble: assert (!(d_stall && d_bubble));
         a_r3_stall_pairs_with_bubble: assert (d_stall == (f_stall && e_bubble && !d_bubble) || !d_stall);
         a_r6_ret_blocks_fetch: assert (!ret_any || f_stall);
         a_r5_taken_jump_quiet: assert (!(e_op == OP_JCC && e_cond && !ret_any && !ld_op)
                                        || {f_stall, d_stall, d_bubble, e_bubble} == 4'b0000);
         a_r9_no_reg_never_stalls: assert (!(e_dst_m == NO_REG) || !d_stall);
         a_r8_mispredict_bubbles: assert (!(e_op == OP_JCC && !e_cond) || (d_bubble && e_bubble && !d_stall));
         a_r1_quiet_when_idle: assert (ret_any || ld_op || e_op == OP_JCC
                                       || {f_stall, d_stall, d_bubble, e_bubble} == 4'b0000);
      end
   end
endmodule

bind pipe_hazard_ctl pipe_hazard_ctl_chk #(
   .REG_W(REG_W), .OP_W(OP_W), .OP_LOAD(OP_LOAD), .OP_POP(OP_POP),
   .OP_JCC(OP_JCC), .OP_RET(OP_RET)
) u_chk (
   .d_src_a(d_src_a), .d_src_b(d_src_b), .d_op(d_op), .e_op(e_op), .m_op(m_op),
   .e_dst_m(e_dst_m), .e_cond(e_cond), .f_stall(f_stall), .d_stall(d_stall),
   .d_bubble(d_bubble), .e_bubble(e_bubble)
);

// File: tb/tb_pipe_hazard_ctl.sv
module tb_pipe_hazard_ctl;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG_CYCLES = 100000;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [3:0] d_src_a, d_src_b, d_op, e_op, m_op, e_dst_m;
   logic       e_cond;
   logic       f_stall, d_stall, d_bubble, e_bubble;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   pipe_hazard_ctl dut (
      .d_src_a(d_src_a), .d_src_b(d_src_b), .d_op(d_op), .e_op(e_op), .m_op(m_op),
      .e_dst_m(e_dst_m), .e_cond(e_cond), .f_stall(f_stall), .d_stall(d_stall),
      .d_bubble(d_bubble), .e_bubble(e_bubble)
   );

   localparam logic [3:0] OPS [6] = '{4'd0, 4'd5, 4'd11, 4'd7, 4'd9, 4'd2};
   localparam logic [3:0] REGS [3] = '{4'd1, 4'd2, 4'd15};

   task automatic check4(input string tag, input logic [3:0] got, input logic [3:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: d=%0d e=%0d m=%0d cond=%0b srcA=%0d srcB=%0d dst=%0d actual=%b expected=%b",
                  tag, d_op, e_op, m_op, e_cond, d_src_a, d_src_b, e_dst_m, got, exp);
      end
   endtask

   initial begin
      d_src_a = 4'd15; d_src_b = 4'd15; d_op = 4'd0; e_op = 4'd0; m_op = 4'd0;
      e_dst_m = 4'd15; e_cond = 1'b0;
      @(negedge clk);
      // R1: idle pipeline, nothing asserted
      check4("R1", {f_stall, d_stall, d_bubble, e_bubble}, 4'b0000);

      for (int di = 0; di < 6; di++)
      for (int ei = 0; ei < 6; ei++)
      for (int mi = 0; mi < 6; mi++)
      for (int c = 0; c < 2; c++)
      for (int ai = 0; ai < 3; ai++)
      for (int bi = 0; bi < 3; bi++)
      for (int ti = 0; ti < 3; ti++) begin
         logic lu, mp, rt, ldop, near;
         logic [3:0] exp;
         string tag;
         @(posedge clk);
         d_op = OPS[di]; e_op = OPS[ei]; m_op = OPS[mi]; e_cond = c[0];
         d_src_a = REGS[ai]; d_src_b = REGS[bi]; e_dst_m = REGS[ti];
         @(negedge clk);
         ldop = (e_op == 4'd5) || (e_op == 4'd11);
         near = (e_dst_m == d_src_a) || (e_dst_m == d_src_b);
         lu   = ldop && near && (e_dst_m != 4'd15);
         mp   = (e_op == 4'd7) && !e_cond;
         rt   = (d_op == 4'd9) || (e_op == 4'd9) || (m_op == 4'd9);
         if (lu)           exp = 4'b1101;
         else if (mp && rt) exp = 4'b1011;
         else if (mp)      exp = 4'b0011;
         else if (rt)      exp = 4'b1010;
         else              exp = 4'b0000;
         if (lu && rt)              tag = "R7";
         else if (mp && rt)         tag = "R8";
         else if (lu)               tag = "R2 R3";
         else if (ldop && near)     tag = "R9";
         else if (mp)               tag = "R4";
         else if (rt)               tag = "R6";
         else if (e_op == 4'd7)     tag = "R5";
         else                       tag = "R1";
         check4(tag, {f_stall, d_stall, d_bubble, e_bubble}, exp);
         // R10: decode never both held and flushed
         check4("R10", {2'b00, d_stall && d_bubble, 1'b0}, 4'b0000);
      end

      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule